// File: doc/BRIEF.md
# Maskable Interrupt Flag and Vector Controller

This block collects up to 32 maskable interrupt requests, holds a pending flag for each, and presents the highest-priority request that may be serviced to the core as a vector fetch address. A request can be serviced only when its flag is set, its enable bit is set and the global mask is clear. While the core is halted for real-time debug, a second enable set further limits service to time-critical sources. The vector address is built from one of two page pointers, one for core-owned vectors and one for host-owned vectors. Software uses a small register port to read and clear flags, to program the enables and pointers, and to change the mask.

A three-state controller sequences each service. In ARBITRATE it waits for an eligible request. On the next edge it moves to OFFER, latches the winning vector number and raises the valid output. In OFFER, an acknowledge from the core moves it to SERVICE. The same edge clears that flag, saves the mask and sets it. If the offered request stops being eligible before the acknowledge arrives, OFFER drops back to ARBITRATE (the withdraw transition). In SERVICE, a return strobe restores the saved mask and goes back to ARBITRATE. A software reset forces ARBITRATE from any state. A higher-priority request that arrives during OFFER does not displace the request already offered.

Register port addresses: 0 = pending flags (a write clears each bit written as 1), 1 = enable, 2 = debug time-critical enable, 3 = core vector pointer (16 bits), 4 = host vector pointer (16 bits), 5 = global mask in bit 0. Reads are combinational.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A high bit on `irq_req` at a rising edge sets the matching pending flag. The flag can be read back at register address 0 after that edge.
- R2: A write to address 0 clears each flag whose data bit is 1 and leaves the flags written with 0 unchanged. Writing back the value just read therefore clears every pending flag.
- R3: An acknowledge while a vector is offered clears the flag of the offered vector and no other flag.
- R4: A device reset clears all flags and all enable bits and sets the global mask to 1. A software reset clears all flags, sets the mask to 1 and returns the controller to ARBITRATE, but leaves the enable and debug enable registers unchanged.
- R5: No vector is offered while the global mask is 1. An acknowledge sets the mask, and the return strobe restores the mask value held before that acknowledge.
- R6: Among the eligible requests, the lowest vector number is offered. `vec_valid` rises on the second rising edge after the request edge.
- R7: Vectors 16 to 23 are fetched through the host pointer and all other vectors through the core pointer. The address is the pointer in bits 23:8 and the vector number times 8 in bits 7:0.
- R8: A request that arrives on the same edge as a write-1-clear of the same bit leaves that flag set.
- R9: While `dbg_halt` is 1, a request is eligible only if its bits are set in both the enable and debug enable registers. When `dbg_halt` returns to 0, the normal enables alone decide eligibility.
- R10: If the offered request stops being eligible before an acknowledge, `vec_valid` falls and the controller returns to ARBITRATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset strobe, synchronous |
| irq_req | input | 32 | Interrupt request lines, one per vector |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| dbg_halt | input | 1 | Core halted in real-time debug |
| ack | input | 1 | Core acknowledges the offered vector |
| svc_return | input | 1 | Core returns from the service routine |
| vec_valid | output | 1 | A vector is offered |
| vec_num | output | 5 | Offered vector number |
| vec_addr | output | 24 | Byte address of the offered vector slot |

## Verification
The bench targets the same-edge race between a request and a write-1-clear of that bit. A design that let the clear win would lose the interrupt. It also checks that a write-back of the read value clears only the flags that were set, which a design that loaded the written value instead of clearing with it would get wrong. Simultaneous requests check that the lowest number wins. Vector 18 checks the choice of pointer, which a wrong range decode would send to the core page. Debug-halt filtering is checked in both directions. A software reset with all enables set checks that the enables survive. The withdraw path is checked because an offer that stays valid after its flag is cleared would dispatch a stale vector.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_ARB   = 2'd0,
        ST_OFFER = 2'd1,
        ST_BUSY  = 2'd2
    } ctl_state_t;

    localparam logic [2:0] RA_FLAG = 3'd0;
    localparam logic [2:0] RA_EN   = 3'd1;
    localparam logic [2:0] RA_DBG  = 3'd2;
    localparam logic [2:0] RA_CPTR = 3'd3;
    localparam logic [2:0] RA_HPTR = 3'd4;
    localparam logic [2:0] RA_MASK = 3'd5;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               w1c_en,
    input  logic [NUM_SRC-1:0] w1c_data,
    input  logic               ack_clr,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] flags
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        logic clr_hit;
        assign clr_hit = (w1c_en && w1c_data[i]) ||
                         (ack_clr && (ack_idx == IDX_W'(i)));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (soft_rst) begin
                flags[i] <= 1'b0;
            end else if (irq_req[i]) begin
                flags[i] <= 1'b1;          // request beats clear (R8)
            end else if (clr_hit) begin
                flags[i] <= 1'b0;
            end
        end
    end

    // R1 / R8: every request line high at an edge leaves its flag set
    p_req_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((|irq_req) && !soft_rst) |=> ((flags & $past(irq_req)) == $past(irq_req)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] eligible,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = |eligible;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
    parameter int NUM_SRC = 32,
    parameter int PTR_W   = 16,
    parameter int HOST_LO = 16,
    parameter int HOST_HI = 23,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int SLOT_W = 8,
    localparam int ADDR_W = PTR_W + SLOT_W
) (
    input  logic [IDX_W-1:0]  num,
    input  logic [PTR_W-1:0]  core_ptr,
    input  logic [PTR_W-1:0]  host_ptr,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [IDX_W-1:0] H_LO = IDX_W'(HOST_LO);
    localparam logic [IDX_W-1:0] H_HI = IDX_W'(HOST_HI);

    logic              is_host;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        is_host = (num >= H_LO) && (num <= H_HI);
        slot    = SLOT_W'({num, 3'b000});
        addr    = {(is_host ? host_ptr : core_ptr), slot};
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int PTR_W   = 16,
    parameter int HOST_LO = 16,
    parameter int HOST_HI = 23,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int ADDR_W = PTR_W + 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic               dbg_halt,
    input  logic               ack,
    input  logic               svc_return,
    output logic               vec_valid,
    output logic [IDX_W-1:0]   vec_num,
    output logic [ADDR_W-1:0]  vec_addr
);
    import irq_pkg::*;

    ctl_state_t         state_q, state_d;
    logic [IDX_W-1:0]   num_q;
    logic [NUM_SRC-1:0] flags, en_q, dbg_q, eligible;
    logic [PTR_W-1:0]   cptr_q, hptr_q;
    logic               gmask_q, saved_q;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic               ack_take, ret_take, offer_live;

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .irq_req  (irq_req),
        .w1c_en   (reg_we && (reg_addr == RA_FLAG)),
        .w1c_data (reg_wdata),
        .ack_clr  (ack_take),
        .ack_idx  (num_q),
        .flags    (flags)
    );

    always_comb begin
        eligible = flags & en_q & (dbg_halt ? dbg_q : {NUM_SRC{1'b1}});
        if (gmask_q) eligible = '0;
    end

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .eligible (eligible),
        .any      (pick_any),
        .idx      (pick_idx)
    );

    irq_vec_map #(
        .NUM_SRC (NUM_SRC),
        .PTR_W   (PTR_W),
        .HOST_LO (HOST_LO),
        .HOST_HI (HOST_HI)
    ) u_map (
        .num      (num_q),
        .core_ptr (cptr_q),
        .host_ptr (hptr_q),
        .addr     (vec_addr)
    );

    // Output process
    always_comb begin
        vec_valid  = (state_q == ST_OFFER);
        vec_num    = num_q;
        ack_take   = vec_valid && ack && !soft_rst;
        ret_take   = (state_q == ST_BUSY) && svc_return && !soft_rst;
        offer_live = eligible[num_q];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARB:   if (pick_any) state_d = ST_OFFER;
            ST_OFFER: begin
                if (ack)              state_d = ST_BUSY;
                else if (!offer_live) state_d = ST_ARB;
            end
            ST_BUSY:  if (svc_return) state_d = ST_ARB;
            default:  state_d = ST_ARB;
        endcase
        if (soft_rst) state_d = ST_ARB;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARB;
            num_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ARB && state_d == ST_OFFER) num_q <= pick_idx;
        end
    end

    // Programmable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            dbg_q   <= '0;
            cptr_q  <= '0;
            hptr_q  <= '0;
            gmask_q <= 1'b1;
            saved_q <= 1'b1;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    RA_EN:   en_q    <= reg_wdata;
                    RA_DBG:  dbg_q   <= reg_wdata;
                    RA_CPTR: cptr_q  <= reg_wdata[PTR_W-1:0];
                    RA_HPTR: hptr_q  <= reg_wdata[PTR_W-1:0];
                    RA_MASK: gmask_q <= reg_wdata[0];
                    default: ;
                endcase
            end
            if (soft_rst) begin
                gmask_q <= 1'b1;
                saved_q <= 1'b1;
            end else if (ack_take) begin
                saved_q <= gmask_q;
                gmask_q <= 1'b1;
            end else if (ret_take) begin
                gmask_q <= saved_q;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_FLAG: reg_rdata = flags;
            RA_EN:   reg_rdata = en_q;
            RA_DBG:  reg_rdata = dbg_q;
            RA_CPTR: reg_rdata = NUM_SRC'(cptr_q);
            RA_HPTR: reg_rdata = NUM_SRC'(hptr_q);
            RA_MASK: reg_rdata = NUM_SRC'(gmask_q);
            default: reg_rdata = '0;
        endcase
    end

    // R3: acknowledge clears the offered flag unless re-requested
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !irq_req[num_q]) |=> !flags[num_q]);

    // R5: acknowledge raises the global mask
    p_mask_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> gmask_q);

    // R5: an offer never starts while the mask is set
    p_no_offer_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> !$past(gmask_q));

    // R4: software reset keeps the enable register
    p_en_soft_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !(reg_we && reg_addr == RA_EN)) |=> (en_q == $past(en_q)));
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [31:0] irq_req = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_halt = 1'b0;
    logic        ack = 1'b0;
    logic        svc_return = 1'b0;
    logic        vec_valid;
    logic [4:0]  vec_num;
    logic [23:0] vec_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [15:0] CPTR = 16'h12AB;
    localparam logic [15:0] HPTR = 16'h4C00;

    always #2 clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .irq_req(irq_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dbg_halt(dbg_halt), .ack(ack),
        .svc_return(svc_return), .vec_valid(vec_valid), .vec_num(vec_num),
        .vec_addr(vec_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1 d = reg_rdata;
    endtask

    task automatic req(input logic [31:0] bits);
        irq_req = bits;
        tick(1);
        irq_req = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic do_ret();
        svc_return = 1'b1; tick(1); svc_return = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R4 reset flags", v, 32'h0);
        rd(3'd1, v); check("R4 reset enable", v, 32'h0);
        rd(3'd5, v); check("R4 reset mask", v, 32'h1);
        check("R4 reset valid", {31'b0, vec_valid}, 32'h0);
    endtask

    task automatic t_set_and_w1c();
        logic [31:0] v;
        req(32'h0000_0088);
        rd(3'd0, v); check("R1 flags set", v, 32'h88);
        tick(2);
        check("R5 masked no offer", {31'b0, vec_valid}, 32'h0);
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, v); check("R2 write zero keeps", v, 32'h88);
        req(32'h0000_0400);
        rd(3'd0, v);
        wr(3'd0, v);
        rd(3'd0, v); check("R2 write-back clears all", v, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        req(32'h4);
        irq_req = 32'h4; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h4;
        tick(1);
        irq_req = '0; reg_we = 1'b0;
        rd(3'd0, v); check("R8 request beats clear", v, 32'h4);
        wr(3'd0, 32'h4);
        rd(3'd0, v); check("R2 plain clear", v, 32'h0);
    endtask

    task automatic t_prio_ack();
        logic [31:0] v;
        wr(3'd3, {16'h0, CPTR});
        wr(3'd4, {16'h0, HPTR});
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0);
        req(32'h0000_0220);
        check("R6 not yet valid", {31'b0, vec_valid}, 32'h0);
        tick(1);
        check("R6 valid", {31'b0, vec_valid}, 32'h1);
        check("R6 lowest wins", {27'b0, vec_num}, 32'd5);
        check("R7 core address", {8'h0, vec_addr}, {8'h0, CPTR, 8'd40});
        do_ack();
        check("R3 valid drops", {31'b0, vec_valid}, 32'h0);
        rd(3'd0, v); check("R3 only offered flag cleared", v, 32'h200);
        rd(3'd5, v); check("R5 mask set on ack", v, 32'h1);
        do_ret();
        rd(3'd5, v); check("R5 mask restored", v, 32'h0);
        tick(1);
        check("R6 next vector", {27'b0, vec_num}, 32'd9);
        check("R6 next valid", {31'b0, vec_valid}, 32'h1);
        do_ack(); do_ret();
    endtask

    task automatic t_host();
        req(32'h0004_0000);
        tick(1);
        check("R7 host valid", {31'b0, vec_valid}, 32'h1);
        check("R7 host address", {8'h0, vec_addr}, {8'h0, HPTR, 8'h90});
        do_ack(); do_ret();
    endtask

    task automatic t_debug();
        wr(3'd2, 32'h0000_1000);
        dbg_halt = 1'b1;
        req(32'h0000_1010);
        tick(1);
        check("R9 debug picks time-critical", {27'b0, vec_num}, 32'd12);
        do_ack(); do_ret();
        tick(2);
        check("R9 non-critical held", {31'b0, vec_valid}, 32'h0);
        dbg_halt = 1'b0;
        tick(2);
        check("R9 released after halt", {26'b0, vec_valid, vec_num}, {26'b0, 1'b1, 5'd4});
        do_ack(); do_ret();
    endtask

    task automatic t_withdraw();
        req(32'h80);
        tick(1);
        check("R10 offered", {31'b0, vec_valid}, 32'h1);
        wr(3'd0, 32'h80);
        tick(1);
        check("R10 withdrawn", {31'b0, vec_valid}, 32'h0);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        req(32'h8);
        tick(1);
        soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
        rd(3'd0, v); check("R4 soft clears flags", v, 32'h0);
        rd(3'd1, v); check("R4 soft keeps enable", v, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R4 soft keeps debug enable", v, 32'h1000);
        rd(3'd5, v); check("R4 soft sets mask", v, 32'h1);
        check("R4 soft drops offer", {31'b0, vec_valid}, 32'h0);
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_set_and_w1c();
        t_race();
        t_prio_ack();
        t_host();
        t_debug();
        t_withdraw();
        t_soft();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule